// File: doc/BRIEF.md
# SDRAM Mode Register and Read-Latency Pipeline

This block models the device side of a single-data-rate synchronous DRAM's command handling for one bank. Each clock edge registers one command: NOP, READ, WRITE or LOAD MODE. A load-mode command writes a mode word. That word sets the burst length, the read latency in clocks and whether writes burst. Reads and writes then run against a small internal word array, using the burst order and timing that the mode word selects.

Read data leaves as a stream with a valid strobe, `rd_valid`. A separate output enable, `dq_oe`, marks the cycles in which the data pins would be driven. It rises one cycle before the first valid word. There is no ready input and so no back-pressure. A read burst cannot be stalled, so the consumer must take every beat in the cycle it is marked valid. Write data is also taken without a handshake: one word per edge, for as many edges as the write burst lasts.

Top module: `sdr_cmd_core`

## Requirements
- R1: After reset, `dq_oe`, `rd_valid` and `mode_err` are low. The mode after reset is burst length 1, read latency 2 and burst writes (M9 = 0).
- R2: A LOAD MODE word is accepted only if all of these hold: bits 8:7 are 00, bit 3 (burst type) is 0 (sequential), bits 2:0 (burst code) are 000, 001, 010 or 011 (giving 1, 2, 4 or 8 beats), and bits 6:4 (latency code) are 010 (2 clocks) or 011 (3 clocks). Bit 9 selects the write mode. An accepted word governs every command registered after the load edge.
- R3: Any other LOAD MODE word leaves the mode unchanged. It also drives `mode_err` high for exactly the one cycle that follows the load edge.
- R4: When a READ is registered at edge n with latency m, `dq_oe` is high after edge n+m−1 and `rd_valid` first goes high after edge n+m.
- R5: A read burst of length BL holds `rd_valid` high for BL consecutive cycles. At the edge after the last beat, both `rd_valid` and `dq_oe` drop.
- R6: Beat i of a burst uses the column whose bits above log2(BL) come from the start column and whose low log2(BL) bits equal (start + i) mod BL. The addresses therefore wrap inside an aligned block.
- R7: With M9 = 0, a WRITE registered at edge n stores the `wdata` of edges n…n+BL−1 into beats 0…BL−1, in the order of R6.
- R8: With M9 = 1, a WRITE stores only the word given with the command. `wdata` on the following NOP cycles changes nothing, while reads still burst.
- R9: A READ registered during a read burst drops `rd_valid` and `dq_oe` at its own edge. It then runs its own latency count from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all commands are registered on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 2 | Command: 00 NOP, 01 READ, 10 WRITE, 11 LOAD MODE |
| col | input | COL_W | Start column for READ and WRITE |
| mode_word | input | 10 | Mode word for LOAD MODE (bits M9..M0) |
| wdata | input | DW | Write data, one word per edge of a write burst |
| rdata | output | DW | Read data beat |
| rd_valid | output | 1 | Marks `rdata` as a valid beat |
| dq_oe | output | 1 | Data-pin drive enable |
| mode_err | output | 1 | One-cycle pulse after a rejected mode word |

## Verification
Reads are tried under both latencies and under burst lengths 1, 4 and 8. This separates an off-by-one in the enable edge from one in the data edge, and it shows a burst that runs short or long. Start columns in the middle of a block tell wrapping addresses apart from linear ones. Write bursts run with M9 clear and with M9 set, and extra write words are driven after the command; the read-back then shows whether stray words landed. Six reserved mode words are each followed by a read that still shows the old mode. A READ issued mid-burst shows whether truncation drops the bus at the right edge.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
  localparam int MODE_W = 10;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'b00,
    CMD_READ  = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_LOAD  = 2'b11
  } cmd_t;

  typedef struct packed {
    logic [1:0] bl_log;    // log2 of burst length
    logic       cas3;      // 1: latency 3, 0: latency 2
    logic       wr_single; // writes touch one location
  } mode_t;

  function automatic logic word_legal(input logic [MODE_W-1:0] w);
    return (w[8:7] == 2'b00) && !w[3] && !w[2] &&
           ((w[6:4] == 3'b010) || (w[6:4] == 3'b011));
  endfunction

  function automatic mode_t word_decode(input logic [MODE_W-1:0] w);
    mode_t m;
    m.bl_log    = w[1:0];
    m.cas3      = w[4];
    m.wr_single = w[9];
    return m;
  endfunction
endpackage

// File: rtl/sdr_mode_reg.sv
module sdr_mode_reg
  import sdr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [MODE_W-1:0] word,
  output mode_t             mode,
  output logic              err
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= '{bl_log: 2'd0, cas3: 1'b0, wr_single: 1'b0};
      err  <= 1'b0;
    end else begin
      err <= 1'b0;
      if (load) begin
        if (word_legal(word)) mode <= word_decode(word);
        else                  err  <= 1'b1;
      end
    end
  end

  // R3
  keep_mode_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $stable(mode));

  // R3
  err_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(load));
endmodule

// File: rtl/sdr_burst_addr.sv
module sdr_burst_addr #(
  parameter int COL_W = 4
) (
  input  logic [COL_W-1:0] base,
  input  logic [2:0]       idx,
  input  logic [1:0]       bl_log,
  output logic [COL_W-1:0] addr
);
  logic [COL_W-1:0] mask, sum;

  always_comb begin
    mask = COL_W'((4'd1 << bl_log) - 4'd1);
    sum  = base + COL_W'(idx);
    addr = (base & ~mask) | (sum & mask);
  end
endmodule

// File: rtl/sdr_read_pipe.sv
module sdr_read_pipe
  import sdr_pkg::*;
#(
  parameter int DW    = 16,
  parameter int COL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic [COL_W-1:0] col,
  input  mode_t            mode,
  input  logic [DW-1:0]    rd_word,
  output logic [COL_W-1:0] rd_addr,
  output logic [DW-1:0]    rdata,
  output logic             rvalid,
  output logic             oe
);
  logic [1:0]       dly;
  logic [3:0]       left;
  logic [2:0]       idx;
  logic [COL_W-1:0] base;
  logic [1:0]       blq;

  sdr_burst_addr #(.COL_W(COL_W)) u_raddr (
    .base(base), .idx(idx), .bl_log(blq), .addr(rd_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dly <= '0; left <= '0; idx <= '0; base <= '0; blq <= '0;
      rdata <= '0; rvalid <= 1'b0; oe <= 1'b0;
    end else if (start) begin
      dly    <= mode.cas3 ? 2'd2 : 2'd1;
      left   <= 4'd1 << mode.bl_log;
      idx    <= '0;
      base   <= col;
      blq    <= mode.bl_log;
      rvalid <= 1'b0;
      oe     <= 1'b0;
    end else if (abort) begin
      dly <= '0; left <= '0; rvalid <= 1'b0; oe <= 1'b0;
    end else if (dly != 2'd0) begin
      dly    <= dly - 2'd1;
      rvalid <= 1'b0;
      if (dly == 2'd1) oe <= 1'b1;
    end else if (left != 4'd0) begin
      rdata  <= rd_word;
      rvalid <= 1'b1;
      oe     <= 1'b1;
      left   <= left - 4'd1;
      idx    <= idx + 3'd1;
    end else begin
      rvalid <= 1'b0;
      oe     <= 1'b0;
    end
  end

  // R4
  oe_before_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rvalid) |-> $past(oe));

  // R5
  valid_implies_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> oe);

  // R9
  new_read_drops_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!rvalid && !oe));

  logic [3:0] run_len;
  always_ff @(posedge clk) begin
    if (!rst_n)      run_len <= '0;
    else if (rvalid) run_len <= run_len + 4'd1;
    else             run_len <= '0;
  end

  // R5
  burst_not_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> (run_len < (4'd1 << blq)));
endmodule

// File: rtl/sdr_cmd_core.sv
module sdr_cmd_core
  import sdr_pkg::*;
#(
  parameter int DW    = 16,
  parameter int COL_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                cmd,
  input  logic [COL_W-1:0]          col,
  input  logic [sdr_pkg::MODE_W-1:0] mode_word,
  input  logic [DW-1:0]             wdata,
  output logic [DW-1:0]             rdata,
  output logic                      rd_valid,
  output logic                      dq_oe,
  output logic                      mode_err
);
  localparam int DEPTH = 1 << COL_W;

  cmd_t             cmd_q;
  mode_t            mode;
  logic [DW-1:0]    mem [DEPTH];
  logic [COL_W-1:0] rd_addr, waddr, wa, wbase;
  logic [2:0]       wleft, widx;
  logic [1:0]       wbl;
  logic             we;

  assign cmd_q = cmd_t'(cmd);

  sdr_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .load(cmd_q == CMD_LOAD),
    .word(mode_word), .mode(mode), .err(mode_err)
  );

  sdr_read_pipe #(.DW(DW), .COL_W(COL_W)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .start(cmd_q == CMD_READ),
    .abort(cmd_q == CMD_WRITE || cmd_q == CMD_LOAD),
    .col(col), .mode(mode), .rd_word(mem[rd_addr]),
    .rd_addr(rd_addr), .rdata(rdata), .rvalid(rd_valid), .oe(dq_oe)
  );

  sdr_burst_addr #(.COL_W(COL_W)) u_waddr (
    .base(wbase), .idx(widx), .bl_log(wbl), .addr(waddr)
  );

  always_comb begin
    we = 1'b0;
    wa = col;
    if (cmd_q == CMD_WRITE) begin
      we = 1'b1;
    end else if (cmd_q == CMD_NOP && wleft != 3'd0) begin
      we = 1'b1;
      wa = waddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wleft <= '0; widx <= '0; wbase <= '0; wbl <= '0;
    end else if (cmd_q == CMD_WRITE) begin
      wbase <= col;
      wbl   <= mode.bl_log;
      widx  <= 3'd1;
      wleft <= mode.wr_single ? 3'd0 : 3'((4'd1 << mode.bl_log) - 4'd1);
    end else if (cmd_q != CMD_NOP) begin
      wleft <= '0;
    end else if (wleft != 3'd0) begin
      wleft <= wleft - 3'd1;
      widx  <= widx + 3'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[wa] <= wdata;
    end
  end

  // R6
  wr_burst_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_NOP && wleft != 3'd0) |-> (((waddr ^ wbase) >> wbl) == '0));

  // R8
  single_write_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_WRITE && mode.wr_single) |=> (wleft == 3'd0));
endmodule

// File: tb/tb_sdr_cmd_core.sv
module tb_sdr_cmd_core;
  localparam int DW = 16;
  localparam int COL_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cmd = 2'b00;
  logic [COL_W-1:0] col = '0;
  logic [9:0] mode_word = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rd_valid, dq_oe, mode_err;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] refm [16];

  always #5 clk = ~clk;

  sdr_cmd_core #(.DW(DW), .COL_W(COL_W)) dut (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .col(col), .mode_word(mode_word),
    .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .dq_oe(dq_oe),
    .mode_err(mode_err)
  );

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] wrap(input logic [3:0] c, input int i, input int bl);
    logic [3:0] m;
    m = 4'(bl - 1);
    return (c & ~m) | (4'(c + 4'(i)) & m);
  endfunction

  function automatic logic [9:0] mw(input logic m9, input logic [2:0] cl, input logic [2:0] bl);
    return {m9, 2'b00, cl, 1'b0, bl};
  endfunction

  task automatic read_check(input logic [3:0] c, input int m, input int bl, input string req);
    logic eoe, ev;
    cmd = 2'b01; col = c;
    for (int k = 0; k <= m + bl; k++) begin
      @(negedge clk);
      if (k == 0) cmd = 2'b00;
      eoe = (k >= m - 1) && (k < m + bl);
      ev  = (k >= m) && (k < m + bl);
      chk(dq_oe == eoe, req, $sformatf("dq_oe k=%0d", k), dq_oe, eoe);
      chk(rd_valid == ev, req, $sformatf("rd_valid k=%0d", k), rd_valid, ev);
      if (ev) chk(rdata == refm[wrap(c, k - m, bl)], "R6",
                  $sformatf("beat %0d col %0d", k - m, c), rdata, refm[wrap(c, k - m, bl)]);
    end
  endtask

  task automatic write_burst(input logic [3:0] c, input int driven, input int eff,
                             input int bl, input logic [15:0] seed);
    cmd = 2'b10; col = c; wdata = seed;
    for (int k = 1; k < driven; k++) begin
      @(negedge clk);
      cmd = 2'b00; wdata = seed + 16'(k);
    end
    @(negedge clk);
    cmd = 2'b00;
    for (int i = 0; i < eff; i++) refm[wrap(c, i, bl)] = seed + 16'(i);
  endtask

  task automatic load_mode(input logic [9:0] w, input logic exp_err, input string req);
    cmd = 2'b11; mode_word = w;
    @(negedge clk);
    cmd = 2'b00;
    chk(mode_err == exp_err, req, $sformatf("mode_err word %0h", w), mode_err, exp_err);
    @(negedge clk);
    chk(mode_err == 1'b0, req, "mode_err one cycle", mode_err, 0);
  endtask

  task automatic t_reset;
    chk(dq_oe == 1'b0, "R1", "dq_oe reset", dq_oe, 0);
    chk(rd_valid == 1'b0, "R1", "rd_valid reset", rd_valid, 0);
    chk(mode_err == 1'b0, "R1", "mode_err reset", mode_err, 0);
  endtask

  task automatic t_default_mode;
    write_burst(4'd5, 1, 1, 1, 16'h1234);
    read_check(4'd5, 2, 1, "R1");
  endtask

  task automatic t_cl3_bl4;
    load_mode(mw(1'b0, 3'b011, 3'b010), 1'b0, "R2");
    write_burst(4'd6, 4, 4, 4, 16'hB000);
    read_check(4'd6, 3, 4, "R4");
    read_check(4'd5, 3, 4, "R6");
  endtask

  task automatic t_bl8_burst_write;
    load_mode(mw(1'b0, 3'b010, 3'b011), 1'b0, "R2");
    write_burst(4'd9, 8, 8, 8, 16'hC000);
    read_check(4'd12, 2, 8, "R7");
  endtask

  task automatic t_single_write;
    load_mode(mw(1'b1, 3'b010, 3'b011), 1'b0, "R2");
    write_burst(4'd10, 8, 1, 8, 16'hD000);
    read_check(4'd8, 2, 8, "R8");
  endtask

  task automatic t_reserved;
    load_mode(10'b0_01_010_0_010, 1'b1, "R3");
    load_mode(10'b0_10_010_0_010, 1'b1, "R3");
    load_mode(mw(1'b0, 3'b001, 3'b000), 1'b1, "R3");
    load_mode(mw(1'b0, 3'b100, 3'b000), 1'b1, "R3");
    load_mode(mw(1'b0, 3'b011, 3'b100), 1'b1, "R3");
    load_mode(10'b0_00_011_1_000, 1'b1, "R3");
    read_check(4'd8, 2, 8, "R3");
  endtask

  task automatic t_truncate;
    cmd = 2'b01; col = 4'd0;
    for (int k = 0; k <= 3; k++) begin
      @(negedge clk);
      if (k == 0) cmd = 2'b00;
      if (k >= 2) chk(rd_valid == 1'b1 && rdata == refm[k - 2], "R5",
                      $sformatf("first burst beat %0d", k - 2), rdata, refm[k - 2]);
    end
    read_check(4'd13, 2, 8, "R9");
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) refm[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_default_mode();
    t_cl3_bl4();
    t_bl8_burst_write();
    t_single_write();
    t_reserved();
    t_truncate();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule